// File: doc/BRIEF.md
# Dual-Thread Slack Fetch and Frequency Arbiter

This block steers two redundantly executed applications. Each application has a leading thread and a trailing thread. Both leading threads share one two-thread core, and both trailing threads share a second two-thread core. The arbiter keeps one slack counter per application. The counter holds how many instructions the leader has committed beyond its trailer. Each counter is sorted into one of four zones using three thresholds: 80, 700 and 1000. From those zones the block decides, every cycle, which thread each core may fetch.

Once per frequency interval the block also moves the trailing core's clock level. The level counts in tenths of peak. It falls one step while both applications stay close enough. It jumps straight to peak when either application falls behind.

Inputs are per-application commit pulses and the in-flight instruction count of each thread. Outputs are a one-hot-or-zero fetch grant per core and the frequency level.

Top module: `slack_fetch_freq_arbiter`

## Requirements
- R1: Each slack counter resets to 0. A leader commit alone adds 1 and a trailer commit alone subtracts 1. Both commits in the same cycle leave the counter unchanged.
- R2: A slack counter saturates at 0 and at 2^SLACK_W-1, which is 2047 by default. It never wraps.
- R3: A trailing thread may be fetched only when its application's slack is strictly above TH0 (80).
- R4: A leading thread may be fetched only when its application's slack is at or below TH2 (1000).
- R5: When both threads of a core are candidates, the thread with the smaller in-flight count is fetched. With the default setting, a tie goes to thread 0. Grant bit i always stands for the thread of application i.
- R6: On the trailing core, if exactly one application's slack is above TH2, that application's trailer is fetched whatever the in-flight counts say.
- R7: Each core gets at most one grant per cycle. A core with no eligible thread gets none.
- R8: The frequency level resets to the peak level 10. It changes only at interval boundaries, every INTERVAL (1000) cycles. The first boundary is the 1000th rising edge after reset is released.
- R9: At a boundary, if either slack is above TH1 (700), the level is set to peak.
- R10: At a boundary where both slacks are at or below TH1, the level drops by one step. It never goes below MIN_LEVEL (1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_commit | input | 2 | Per-application leader commit pulse |
| trail_commit | input | 2 | Per-application trailer commit pulse |
| lead_icnt0 | input | ICNT_W | In-flight count, leader of application 0 |
| lead_icnt1 | input | ICNT_W | In-flight count, leader of application 1 |
| trail_icnt0 | input | ICNT_W | In-flight count, trailer of application 0 |
| trail_icnt1 | input | ICNT_W | In-flight count, trailer of application 1 |
| lead_grant | output | 2 | Leading-core fetch grant, one-hot or zero |
| trail_grant | output | 2 | Trailing-core fetch grant, one-hot or zero |
| freq_level | output | LEVEL_W | Trailing-core frequency in tenths of peak |

## Verification
The fetch function is tried with slack values placed on each side of every threshold, for each application in turn.
- Slack at exactly 80 against 81 tells the strict trailer test apart from an inclusive one.
- Slack at 1000 against 1001 does the same for the leader test.
- Cases where both threads are candidates, with unequal and with equal counts, separate the count-based choice from the fixed tie rule.
- A case where one application is over the top threshold while the count favours the other thread shows the catch-up priority.

The frequency path is driven across ten idle intervals to reach the floor, then given a slack of 701 to show the jump to peak. A long run of leader commits followed by trailer commits shows whether the counter saturated or wrapped.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
   // slack classification against the three thresholds
   typedef enum logic [1:0] {
      ZONE_LOW    = 2'd0,   // slack <= TH0
      ZONE_TARGET = 2'd1,   // TH0 < slack <= TH1
      ZONE_HIGH   = 2'd2,   // TH1 < slack <= TH2
      ZONE_OVER   = 2'd3    // slack > TH2
   } slack_zone_e;
endpackage

// File: rtl/sfa_slack_tracker.sv
module sfa_slack_tracker
   import sfa_pkg::*;
#(
   parameter int SLACK_W = 11,
   parameter int TH0     = 80,
   parameter int TH1     = 700,
   parameter int TH2     = 1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lead_commit,
   input  logic               trail_commit,
   output logic [SLACK_W-1:0] slack,
   output slack_zone_e        zone
);
   localparam logic [SLACK_W-1:0] MAX_V = '1;
   localparam logic [SLACK_W-1:0] TH0_V = SLACK_W'(TH0);
   localparam logic [SLACK_W-1:0] TH1_V = SLACK_W'(TH1);
   localparam logic [SLACK_W-1:0] TH2_V = SLACK_W'(TH2);
   localparam logic [SLACK_W-1:0] ONE_V = SLACK_W'(1);

   logic grow, shrink;
   assign grow   = lead_commit && !trail_commit;
   assign shrink = trail_commit && !lead_commit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slack <= '0;
      end else if (grow && (slack != MAX_V)) begin
         slack <= slack + ONE_V;
      end else if (shrink && (slack != '0)) begin
         slack <= slack - ONE_V;
      end
   end

   always_comb begin
      if (slack <= TH0_V)      zone = ZONE_LOW;
      else if (slack <= TH1_V) zone = ZONE_TARGET;
      else if (slack <= TH2_V) zone = ZONE_HIGH;
      else                     zone = ZONE_OVER;
   end

   // R1
   pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_commit && trail_commit) |=> $stable(slack));
   // R2
   floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((slack == '0) && !lead_commit) |=> (slack == '0));
   // R2
   ceil_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((slack == MAX_V) && !trail_commit) |=> (slack == MAX_V));
   // R1
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grow && (slack != MAX_V)) |=> (slack == $past(slack) + ONE_V));
endmodule

// File: rtl/sfa_thread_picker.sv
module sfa_thread_picker #(
   parameter int ICNT_W     = 7,
   parameter int TIE_ROTATE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        elig,
   input  logic [1:0]        urgent,
   input  logic [ICNT_W-1:0] icnt0,
   input  logic [ICNT_W-1:0] icnt1,
   output logic [1:0]        grant
);
   logic [1:0] cand;
   logic [1:0] tie_pick;
   logic       tie;

   always_comb begin
      cand = elig;
      if ((elig & urgent) != 2'b00) cand = elig & urgent;
   end

   assign tie = (cand == 2'b11) && (icnt0 == icnt1);

   generate
      if (TIE_ROTATE == 0) begin : g_tie_fixed
         assign tie_pick = 2'b01;
      end else begin : g_tie_rotate
         logic last_one_q;
         always_ff @(posedge clk) begin
            if (!rst_n)   last_one_q <= 1'b1;
            else if (tie) last_one_q <= ~last_one_q;
         end
         assign tie_pick = last_one_q ? 2'b01 : 2'b10;
      end
   endgenerate

   always_comb begin
      unique case (cand)
         2'b01:   grant = 2'b01;
         2'b10:   grant = 2'b10;
         2'b11: begin
            if (icnt0 < icnt1)      grant = 2'b01;
            else if (icnt1 < icnt0) grant = 2'b10;
            else                    grant = tie_pick;
         end
         default: grant = 2'b00;
      endcase
   end

   // R7
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R7
   grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & ~elig) == 2'b00));
   // R7
   idle_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (elig == 2'b00) |-> (grant == 2'b00));
   // R5
   icount_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((elig == 2'b11) && (urgent == 2'b00) && (icnt1 < icnt0)) |-> (grant == 2'b10));
   // R6
   urgent_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((elig & urgent) == 2'b10) |-> (grant == 2'b10));
endmodule

// File: rtl/sfa_freq_governor.sv
module sfa_freq_governor #(
   parameter int INTERVAL   = 1000,
   parameter int PEAK_LEVEL = 10,
   parameter int MIN_LEVEL  = 1,
   parameter int LEVEL_W    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               raise,
   output logic [LEVEL_W-1:0] level
);
   localparam int CNT_W = $clog2(INTERVAL);
   localparam logic [CNT_W-1:0]   LAST_V = CNT_W'(INTERVAL - 1);
   localparam logic [LEVEL_W-1:0] PEAK_V = LEVEL_W'(PEAK_LEVEL);
   localparam logic [LEVEL_W-1:0] MIN_V  = LEVEL_W'(MIN_LEVEL);
   localparam logic [LEVEL_W-1:0] STEP_V = LEVEL_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             tick;

   assign tick = (cnt_q == LAST_V);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= PEAK_V;
      end else if (tick) begin
         if (raise)              level <= PEAK_V;
         else if (level > MIN_V) level <= level - STEP_V;
      end
   end

   // R8
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(level));
   // R10
   level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level >= MIN_V) && (level <= PEAK_V));
   // R10
   level_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !raise && (level > MIN_V)) |=> (level == $past(level) - STEP_V));
   // R9
   level_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && raise) |=> (level == PEAK_V));
endmodule

// File: rtl/slack_fetch_freq_arbiter.sv
module slack_fetch_freq_arbiter
   import sfa_pkg::*;
#(
   parameter int SLACK_W    = 11,
   parameter int ICNT_W     = 7,
   parameter int TH0        = 80,
   parameter int TH1        = 700,
   parameter int TH2        = 1000,
   parameter int INTERVAL   = 1000,
   parameter int PEAK_LEVEL = 10,
   parameter int MIN_LEVEL  = 1,
   parameter int TIE_ROTATE = 0,
   localparam int LEVEL_W   = $clog2(PEAK_LEVEL + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         lead_commit,
   input  logic [1:0]         trail_commit,
   input  logic [ICNT_W-1:0]  lead_icnt0,
   input  logic [ICNT_W-1:0]  lead_icnt1,
   input  logic [ICNT_W-1:0]  trail_icnt0,
   input  logic [ICNT_W-1:0]  trail_icnt1,
   output logic [1:0]         lead_grant,
   output logic [1:0]         trail_grant,
   output logic [LEVEL_W-1:0] freq_level
);
   localparam logic [SLACK_W-1:0] TH0_V = SLACK_W'(TH0);
   localparam logic [SLACK_W-1:0] TH2_V = SLACK_W'(TH2);

   // elaboration-time parameter checks
   generate
      if (!((TH0 < TH1) && (TH1 < TH2))) begin : g_bad_order
         $error("thresholds must be strictly increasing");
      end
      if (TH2 >= (2 ** SLACK_W) - 1) begin : g_bad_width
         $error("slack width too small for top threshold");
      end
      if ((MIN_LEVEL < 1) || (MIN_LEVEL > PEAK_LEVEL)) begin : g_bad_level
         $error("minimum level out of range");
      end
      if (INTERVAL < 2) begin : g_bad_interval
         $error("interval too short");
      end
   endgenerate

   logic [SLACK_W-1:0] slack [2];
   slack_zone_e        zone  [2];
   logic [1:0]         trail_elig, lead_elig, trail_urgent, behind;

   for (genvar a = 0; a < 2; a++) begin : g_app
      sfa_slack_tracker #(
         .SLACK_W (SLACK_W),
         .TH0     (TH0),
         .TH1     (TH1),
         .TH2     (TH2)
      ) u_track (
         .clk          (clk),
         .rst_n        (rst_n),
         .lead_commit  (lead_commit[a]),
         .trail_commit (trail_commit[a]),
         .slack        (slack[a]),
         .zone         (zone[a])
      );

      assign trail_elig[a]   = (zone[a] != ZONE_LOW);
      assign lead_elig[a]    = (zone[a] != ZONE_OVER);
      assign trail_urgent[a] = (zone[a] == ZONE_OVER);
      assign behind[a]       = (zone[a] == ZONE_HIGH) || (zone[a] == ZONE_OVER);

      // R3
      trail_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         trail_grant[a] |-> (slack[a] > TH0_V));
      // R4
      lead_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         lead_grant[a] |-> (slack[a] <= TH2_V));
   end

   sfa_thread_picker #(
      .ICNT_W     (ICNT_W),
      .TIE_ROTATE (TIE_ROTATE)
   ) u_lead_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .elig   (lead_elig),
      .urgent (2'b00),
      .icnt0  (lead_icnt0),
      .icnt1  (lead_icnt1),
      .grant  (lead_grant)
   );

   sfa_thread_picker #(
      .ICNT_W     (ICNT_W),
      .TIE_ROTATE (TIE_ROTATE)
   ) u_trail_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .elig   (trail_elig),
      .urgent (trail_urgent),
      .icnt0  (trail_icnt0),
      .icnt1  (trail_icnt1),
      .grant  (trail_grant)
   );

   sfa_freq_governor #(
      .INTERVAL   (INTERVAL),
      .PEAK_LEVEL (PEAK_LEVEL),
      .MIN_LEVEL  (MIN_LEVEL),
      .LEVEL_W    (LEVEL_W)
   ) u_freq (
      .clk   (clk),
      .rst_n (rst_n),
      .raise (|behind),
      .level (freq_level)
   );
endmodule

// File: tb/slack_fetch_freq_arbiter_test.sv
`timescale 1ns/1ps
module slack_fetch_freq_arbiter_test;
   localparam int INTERVAL = 1000;

   typedef struct packed {
      logic [1:0]  lc;
      logic [1:0]  tc;
      logic [15:0] cyc;
      logic [6:0]  li0, li1, ti0, ti1;
      logic [1:0]  elg, etg;
   } vec_t;

   // slack after each step shown as (s0,s1)
   localparam vec_t VEC [10] = '{
      '{2'b11, 2'b00, 16'd80,   7'd5, 7'd3, 7'd2, 7'd9, 2'b10, 2'b00}, // R3 R5 (80,80)
      '{2'b01, 2'b00, 16'd1,    7'd5, 7'd3, 7'd2, 7'd9, 2'b10, 2'b01}, // R3 (81,80)
      '{2'b10, 2'b00, 16'd1,    7'd5, 7'd3, 7'd2, 7'd9, 2'b10, 2'b01}, // R5 (81,81)
      '{2'b00, 2'b00, 16'd0,    7'd1, 7'd1, 7'd9, 7'd4, 2'b01, 2'b10}, // R5 tie
      '{2'b11, 2'b11, 16'd50,   7'd5, 7'd3, 7'd2, 7'd9, 2'b10, 2'b01}, // R1 (81,81)
      '{2'b00, 2'b01, 16'd10,   7'd5, 7'd3, 7'd2, 7'd9, 2'b10, 2'b10}, // R1 (71,81)
      '{2'b01, 2'b00, 16'd929,  7'd5, 7'd3, 7'd2, 7'd9, 2'b10, 2'b01}, // R4 (1000,81)
      '{2'b01, 2'b00, 16'd1,    7'd1, 7'd9, 7'd9, 7'd2, 2'b10, 2'b01}, // R4 R6 (1001,81)
      '{2'b10, 2'b00, 16'd920,  7'd1, 7'd9, 7'd9, 7'd2, 2'b00, 2'b10}, // R7 (1001,1001)
      '{2'b00, 2'b11, 16'd1006, 7'd1, 7'd9, 7'd9, 7'd2, 2'b01, 2'b00}  // R2 R7 (0,0)
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] lead_commit = 2'b00, trail_commit = 2'b00;
   logic [6:0] lead_icnt0 = 7'd5, lead_icnt1 = 7'd3, trail_icnt0 = 7'd2, trail_icnt1 = 7'd9;
   logic [1:0] lead_grant, trail_grant;
   logic [3:0] freq_level;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   slack_fetch_freq_arbiter uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .lead_commit  (lead_commit),
      .trail_commit (trail_commit),
      .lead_icnt0   (lead_icnt0),
      .lead_icnt1   (lead_icnt1),
      .trail_icnt0  (trail_icnt0),
      .trail_icnt1  (trail_icnt1),
      .lead_grant   (lead_grant),
      .trail_grant  (trail_grant),
      .freq_level   (freq_level)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      lead_commit = 2'b00;
      trail_commit = 2'b00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_cycles(input logic [1:0] lc, input logic [1:0] tc, input int n);
      lead_commit = lc;
      trail_commit = tc;
      repeat (n) @(negedge clk);
      lead_commit = 2'b00;
      trail_commit = 2'b00;
      #1;
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      #1;
      // R1 R4 R5 R8: reset state
      check("R8 reset level", int'(freq_level), 10);
      check("R5 reset lead grant", int'(lead_grant), 2);
      check("R3 reset trail grant", int'(trail_grant), 0);

      for (int i = 0; i < 10; i++) begin
         lead_icnt0  = VEC[i].li0;
         lead_icnt1  = VEC[i].li1;
         trail_icnt0 = VEC[i].ti0;
         trail_icnt1 = VEC[i].ti1;
         run_cycles(VEC[i].lc, VEC[i].tc, int'(VEC[i].cyc));
         check($sformatf("R3/R4/R5/R6/R7 vector %0d lead", i), int'(lead_grant), int'(VEC[i].elg));
         check($sformatf("R3/R4/R5/R6/R7 vector %0d trail", i), int'(trail_grant), int'(VEC[i].etg));
      end

      // R8 R10: level walks down one step per interval to the floor
      do_reset();
      repeat (INTERVAL - 1) @(negedge clk);
      check("R8 before first boundary", int'(freq_level), 10);
      @(negedge clk);
      check("R10 first step down", int'(freq_level), 9);
      for (int k = 2; k <= 10; k++) begin
         repeat (INTERVAL) @(negedge clk);
         check($sformatf("R10 interval %0d", k), int'(freq_level), (10 - k < 1) ? 1 : 10 - k);
      end

      // R9: slack 701 at the boundary forces peak
      run_cycles(2'b01, 2'b00, 701);
      repeat (INTERVAL - 702) @(negedge clk);
      check("R8 hold before boundary", int'(freq_level), 1);
      @(negedge clk);
      check("R9 jump to peak", int'(freq_level), 10);

      // R2: counter saturates at 2047, then 1047 trailer commits leave 1000
      do_reset();
      lead_icnt0 = 7'd1;
      lead_icnt1 = 7'd9;
      run_cycles(2'b01, 2'b00, 2057);
      check("R4 over top after saturation", int'(lead_grant), 2);
      run_cycles(2'b00, 2'b01, 1047);
      check("R2 ceiling saturation trail", int'(trail_grant), 1);
      check("R2 ceiling saturation lead", int'(lead_grant), 1);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule